// File: doc/BRIEF.md
# Frame Job Queue Control Unit

This block is the register-side control unit of a camera front-end. It holds one pending frame job while another frame runs. Software fills a shadow configuration window through a 32-bit register port and issues a queue command. The next start-of-frame strobe promotes the pending job to active. In that same cycle the whole shadow window is copied into an active configuration set, and the pending slot is freed for the next job.

Frame start, frame end, per-output line and statistics-done events arrive as single-cycle input strobes. The unit counts lines for each output and compares the count against a threshold taken from the active configuration. It keeps write-one-to-clear interrupt flags behind an enable mask and drives one registered interrupt line. Abort and reset commands are provided. A latch command freezes a coherent snapshot of the status, frame count, error and line-count registers for software to read.

Register port: a request is taken on a rising edge when `bus_sel` is high. `bus_wr` selects a write. Read data appears on `bus_rdata` after that edge and holds until the next read. Offsets: 0x000 version, 0x004 control, 0x008 status, 0x00C frame count, 0x010 error, 0x014 line counts, 0x018 interrupt enable, 0x01C interrupt flags, 0x040 onward shadow window (one word per entry), 0x080 onward active copy (read-only). Any other offset reads zero.

Top module: `fjq_top`

## Requirements
- R1: The version word reads as major revision in bits 31:24, minor revision in bits 23:20, and zero elsewhere (defaults 2 and 1, giving 0x02100000). The control word always reads zero, and unmapped offsets read zero.
- R2: Writing control bit 0 (queue) while no job is pending sets status bit 0 (queued). Status bit 1 (waiting) is high when a job is queued and no frame is active. Status bit 2 means a frame is active. All zero means idle.
- R3: A start-of-frame strobe while a job is queued clears bit 0, sets bit 2, and sets interrupt flags bit 1 (frame start) and bit 24 (queue ready). In the same cycle it copies every shadow window word into the active copy. The line counters restart at zero.
- R4: A start-of-frame strobe with no job queued changes no job state and sets no flag. It sets error bit 1 (frame without job), which is sticky.
- R5: An end-of-frame strobe while a frame is active clears status bit 2, sets flag bit 0 and increments the frame count at 0x00C. With no frame active the strobe is ignored.
- R6: A queue command while a job is already queued is ignored and sets sticky error bit 0.
- R7: While a frame is active, output k counts its line strobes. Flag bit 8+k sets on the strobe that makes the count equal to bits 15:0 of active word k. A threshold of zero never fires.
- R8: A statistics-done strobe sets flag bit 16.
- R9: Writing the flag register clears the flags whose written bits are one. A flag set by an event in the same cycle as its clear stays set.
- R10: `irq_o` goes high one cycle after any flag is set with its enable bit high, and stays low while the enable register is zero.
- R11: Reads of status, frame count, error and line counts (bits 15:0 output 0, bits 31:16 output 1) return the values captured by the latest latch command (control bit 3). They read zero after reset until the first latch.
- R12: An abort command (control bit 2 is reset, bit 1 is abort) leaves status all zero from the next cycle. Flags, frame count and errors are kept.
- R13: A reset command clears job state, flags, the enable register, errors, counters, latched values and the active copy. It leaves the shadow window intact. Within one control write, reset overrides abort and abort overrides queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| sof_i | input | 1 | Start-of-frame strobe |
| eof_i | input | 1 | End-of-frame strobe |
| line_i | input | NOUT | Per-output line-done strobes |
| stats_i | input | 1 | Statistics-done strobe |
| irq_o | output | 1 | Registered interrupt request |

## Verification
On every cycle, the bound checker tracks the job state transitions. It covers promotion and its two flags, setting the queued bit, overflow error logging, forced idle after abort, the wipe done by the reset command, and interrupt masking. Other properties can only be shown by the bench's scenarios, because they need the register port and a sequence of events. These include the latched read values lagging behind live state until the next latch, threshold matching on an exact line count, set-over-clear priority on the flag register, the shadow copy appearing in the active window, and the shadow window surviving a reset command.

// File: rtl/fjq_pkg.sv
package fjq_pkg;
  localparam int unsigned DW = 32;

  localparam logic [11:0] A_VER  = 12'h000;
  localparam logic [11:0] A_CTRL = 12'h004;
  localparam logic [11:0] A_STAT = 12'h008;
  localparam logic [11:0] A_FRM  = 12'h00C;
  localparam logic [11:0] A_ERR  = 12'h010;
  localparam logic [11:0] A_OUTS = 12'h014;
  localparam logic [11:0] A_IEN  = 12'h018;
  localparam logic [11:0] A_IFLG = 12'h01C;
  localparam logic [11:0] A_CFG  = 12'h040;
  localparam logic [11:0] A_ACT  = 12'h080;

  localparam int unsigned IRQ_EOF   = 0;
  localparam int unsigned IRQ_SOF   = 1;
  localparam int unsigned IRQ_LINE  = 8;
  localparam int unsigned IRQ_STATS = 16;
  localparam int unsigned IRQ_QRDY  = 24;

  typedef struct packed {
    logic wipe;
    logic latch;
    logic abort;
    logic queue;
  } cmd_t;
endpackage

// File: rtl/fjq_sequencer.sv
module fjq_sequencer
  import fjq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  cmd_t          cmd,
  input  logic          sof_i,
  input  logic          eof_i,
  output logic          queued,
  output logic          active,
  output logic          promote,
  output logic          frame_end,
  output logic [DW-1:0] frame_cnt,
  output logic [1:0]    err
);
  logic hold;
  assign hold      = cmd.wipe | cmd.abort;
  assign promote   = sof_i & queued & ~hold;
  assign frame_end = eof_i & active & ~hold & ~promote;

  always_ff @(posedge clk) begin
    if (rst || cmd.wipe) begin
      queued    <= 1'b0;
      active    <= 1'b0;
      frame_cnt <= '0;
      err       <= '0;
    end else if (cmd.abort) begin
      queued <= 1'b0;
      active <= 1'b0;
    end else begin
      if (promote) begin
        queued <= 1'b0;
        active <= 1'b1;
      end else if (frame_end) begin
        active <= 1'b0;
      end
      if (frame_end) frame_cnt <= frame_cnt + 1'b1;
      if (cmd.queue) begin
        if (queued) err[0] <= 1'b1;
        else        queued <= 1'b1;
      end
      if (sof_i && !queued) err[1] <= 1'b1;
    end
  end
endmodule

// File: rtl/fjq_line_unit.sv
module fjq_line_unit #(
  parameter int unsigned NOUT = 2,
  parameter int unsigned CNTW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 restart,
  input  logic                 run,
  input  logic [NOUT-1:0]      line_i,
  input  logic [NOUT*CNTW-1:0] thr,
  output logic [NOUT-1:0]      hit,
  output logic [NOUT*CNTW-1:0] cnt
);
  for (genvar k = 0; k < NOUT; k++) begin : g_out
    logic [CNTW-1:0] cnt_q;
    logic [CNTW-1:0] nxt;
    logic            step;

    assign step = run & ~restart & line_i[k];
    assign nxt  = cnt_q + 1'b1;
    assign hit[k] = step && (thr[k*CNTW +: CNTW] != '0) && (nxt == thr[k*CNTW +: CNTW]);
    assign cnt[k*CNTW +: CNTW] = cnt_q;

    always_ff @(posedge clk) begin
      if (rst || clr || restart) cnt_q <= '0;
      else if (step)             cnt_q <= nxt;
    end
  end
endmodule

// File: rtl/fjq_irq.sv
module fjq_irq #(
  parameter int unsigned FW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [FW-1:0] set_vec,
  input  logic          w1c_we,
  input  logic          en_we,
  input  logic [FW-1:0] wdata,
  output logic [FW-1:0] flags,
  output logic [FW-1:0] en,
  output logic          irq_o
);
  logic [FW-1:0] kill;
  assign kill = w1c_we ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      flags <= '0;
      en    <= '0;
      irq_o <= 1'b0;
    end else begin
      flags <= (flags & ~kill) | set_vec;
      if (en_we) en <= wdata;
      irq_o <= |(flags & en);
    end
  end
endmodule

// File: rtl/fjq_top.sv
module fjq_top
  import fjq_pkg::*;
#(
  parameter int unsigned NCFG      = 8,
  parameter int unsigned NOUT      = 2,
  parameter int unsigned CNTW      = 16,
  parameter logic [7:0]  VER_MAJOR = 8'd2,
  parameter logic [3:0]  VER_MINOR = 4'd1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bus_sel,
  input  logic            bus_wr,
  input  logic [11:0]     bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic            sof_i,
  input  logic            eof_i,
  input  logic [NOUT-1:0] line_i,
  input  logic            stats_i,
  output logic            irq_o
);
  localparam int unsigned IDXW    = $clog2(NCFG);
  localparam logic [11:0] CFG_END = A_CFG + 12'(NCFG * 4);
  localparam logic [11:0] ACT_END = A_ACT + 12'(NCFG * 4);
  localparam logic [DW-1:0] VER_WORD = {VER_MAJOR, VER_MINOR, 20'h0};

  logic wr, rd, aligned, in_cfg, in_act;
  logic [IDXW-1:0] idx;
  cmd_t cmd;

  assign wr      = bus_sel & bus_wr;
  assign rd      = bus_sel & ~bus_wr;
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign in_cfg  = aligned && (bus_addr >= A_CFG) && (bus_addr < CFG_END);
  assign in_act  = aligned && (bus_addr >= A_ACT) && (bus_addr < ACT_END);
  assign idx     = bus_addr[2 +: IDXW];

  always_comb begin
    cmd = '0;
    if (wr && bus_addr == A_CTRL) begin
      cmd.queue = bus_wdata[0];
      cmd.abort = bus_wdata[1];
      cmd.wipe  = bus_wdata[2];
      cmd.latch = bus_wdata[3];
    end
  end

  // job sequencing
  logic queued, active, promote, frame_end;
  logic [DW-1:0] frame_cnt;
  logic [1:0] err;

  fjq_sequencer u_seq (
    .clk, .rst, .cmd, .sof_i, .eof_i,
    .queued, .active, .promote, .frame_end, .frame_cnt, .err
  );

  // shadow window (single write port) and active copy
  logic [DW-1:0] shadow  [NCFG];
  logic [DW-1:0] act_cfg [NCFG];

  always_ff @(posedge clk) begin
    if (wr && in_cfg) shadow[idx] <= bus_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || cmd.wipe) begin
      for (int i = 0; i < NCFG; i++) act_cfg[i] <= '0;
    end else if (promote) begin
      for (int i = 0; i < NCFG; i++) act_cfg[i] <= shadow[i];
    end
  end

  // line thresholds
  logic [NOUT*CNTW-1:0] thr, cnt;
  logic [NOUT-1:0] hit;
  for (genvar k = 0; k < NOUT; k++) begin : g_thr
    assign thr[k*CNTW +: CNTW] = act_cfg[k][CNTW-1:0];
  end

  fjq_line_unit #(.NOUT(NOUT), .CNTW(CNTW)) u_lines (
    .clk, .rst, .clr(cmd.wipe), .restart(promote),
    .run(active & ~cmd.abort & ~cmd.wipe),
    .line_i, .thr, .hit, .cnt
  );

  // interrupt flags
  logic [DW-1:0] set_vec, flags, irq_en;
  always_comb begin
    set_vec = '0;
    set_vec[IRQ_EOF]   = frame_end;
    set_vec[IRQ_SOF]   = promote;
    set_vec[IRQ_STATS] = stats_i;
    set_vec[IRQ_QRDY]  = promote;
    for (int k = 0; k < NOUT; k++) set_vec[IRQ_LINE + k] = hit[k];
  end

  fjq_irq #(.FW(DW)) u_irq (
    .clk, .rst, .clr(cmd.wipe), .set_vec,
    .w1c_we(wr && bus_addr == A_IFLG),
    .en_we(wr && bus_addr == A_IEN),
    .wdata(bus_wdata), .flags, .en(irq_en), .irq_o
  );

  // coherent snapshot
  logic [2:0]    lat_stat;
  logic [DW-1:0] lat_frm, lat_outs;
  logic [1:0]    lat_err;

  always_ff @(posedge clk) begin
    if (rst || cmd.wipe) begin
      lat_stat <= '0;
      lat_frm  <= '0;
      lat_err  <= '0;
      lat_outs <= '0;
    end else if (cmd.latch) begin
      lat_stat <= {active, queued & ~active, queued};
      lat_frm  <= frame_cnt;
      lat_err  <= err;
      lat_outs <= DW'(cnt);
    end
  end

  // registered read data
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd) begin
      if (in_cfg)                  bus_rdata <= shadow[idx];
      else if (in_act)             bus_rdata <= act_cfg[idx];
      else if (bus_addr == A_VER)  bus_rdata <= VER_WORD;
      else if (bus_addr == A_STAT) bus_rdata <= DW'(lat_stat);
      else if (bus_addr == A_FRM)  bus_rdata <= lat_frm;
      else if (bus_addr == A_ERR)  bus_rdata <= DW'(lat_err);
      else if (bus_addr == A_OUTS) bus_rdata <= lat_outs;
      else if (bus_addr == A_IEN)  bus_rdata <= irq_en;
      else if (bus_addr == A_IFLG) bus_rdata <= flags;
      else                         bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/fjq_checker.sv
module fjq_checker
  import fjq_pkg::*;
(
  input logic          clk,
  input logic          rst,
  input cmd_t          cmd,
  input logic          queued,
  input logic          active,
  input logic          promote,
  input logic [1:0]    err,
  input logic [DW-1:0] flags,
  input logic [DW-1:0] irq_en,
  input logic          irq_o
);
  AST_QUEUE_SETS: assert property (@(posedge clk) disable iff (rst)
    (cmd.queue && !queued && !cmd.abort && !cmd.wipe) |=> queued); // R2

  AST_PROMOTE_STATE: assert property (@(posedge clk) disable iff (rst)
    promote |=> (active && !queued)); // R3

  AST_PROMOTE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    promote |=> (flags[IRQ_SOF] && flags[IRQ_QRDY])); // R3

  AST_QUEUE_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (cmd.queue && queued && !cmd.abort && !cmd.wipe) |=> err[0]); // R6

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (rst)
    cmd.abort |=> (!queued && !active)); // R12

  AST_WIPE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    cmd.wipe |=> (flags == '0 && irq_en == '0 && !queued && !active && err == '0)); // R13

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (irq_en == '0) |=> !irq_o); // R10
endmodule

bind fjq_top fjq_checker u_fjq_checker (
  .clk(clk), .rst(rst), .cmd(cmd), .queued(queued), .active(active),
  .promote(promote), .err(err), .flags(flags), .irq_en(irq_en), .irq_o(irq_o)
);

// File: tb/test_fjq_top.sv
module test_fjq_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        sof_i = 1'b0, eof_i = 1'b0, stats_i = 1'b0;
  logic [1:0]  line_i = '0;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fjq_top i_fjq_top (
    .clk, .rst, .bus_sel, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata,
    .sof_i, .eof_i, .line_i, .stats_i, .irq_o
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 12'h000, 32'h0,        32'h0210_0000, 4'd1},   // R1 version
    '{1'b0, 12'h004, 32'h0,        32'h0,         4'd1},   // R1 control reads zero
    '{1'b0, 12'h0FC, 32'h0,        32'h0,         4'd1},   // R1 unmapped
    '{1'b1, 12'h018, 32'h0101_0303, 32'h0,        4'd10},  // R10 enable write
    '{1'b0, 12'h018, 32'h0,        32'h0101_0303, 4'd10},
    '{1'b1, 12'h040, 32'h0000_0003, 32'h0,        4'd3},   // R3 shadow words
    '{1'b1, 12'h044, 32'h0000_0005, 32'h0,        4'd3},
    '{1'b1, 12'h048, 32'hDEAD_BEEF, 32'h0,        4'd3},
    '{1'b0, 12'h040, 32'h0,        32'h0000_0003, 4'd3},
    '{1'b0, 12'h048, 32'h0,        32'hDEAD_BEEF, 4'd3},
    '{1'b0, 12'h080, 32'h0,        32'h0,         4'd3},   // R3 no copy before promotion
    '{1'b0, 12'h01C, 32'h0,        32'h0,         4'd9}
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_latched(logic [11:0] a, output logic [31:0] d);
    wr(12'h004, 32'h8);
    rd(a, d);
  endtask

  task automatic pulse_sof();
    @(negedge clk); sof_i = 1'b1; @(negedge clk); sof_i = 1'b0;
  endtask
  task automatic pulse_eof();
    @(negedge clk); eof_i = 1'b1; @(negedge clk); eof_i = 1'b0;
  endtask
  task automatic pulse_stats();
    @(negedge clk); stats_i = 1'b1; @(negedge clk); stats_i = 1'b0;
  endtask
  task automatic pulse_line(int k, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); line_i[k] = 1'b1; @(negedge clk); line_i[k] = 1'b0;
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    check("R10 reset irq", {31'b0, irq_o}, 32'h0);
    rd(12'h008, d); check("R11 status before any latch", d, 32'h0);
    rd(12'h014, d); check("R11 line counts before any latch", d, 32'h0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      if (VECS[i].wr) wr(VECS[i].addr, VECS[i].data);
      else begin
        rd(VECS[i].addr, d);
        check($sformatf("R%0d table %0d", VECS[i].req, i), d, VECS[i].exp);
      end
    end

    // R2 queue a job
    wr(12'h004, 32'h1);
    rd_latched(12'h008, d); check("R2 queued and waiting", d, 32'h3);

    // R3 promotion
    pulse_sof();
    rd_latched(12'h008, d); check("R3 active after promotion", d, 32'h4);
    rd(12'h01C, d); check("R3 start and queue-ready flags", d, 32'h0100_0002);
    rd(12'h080, d); check("R3 active copy word 0", d, 32'h3);
    rd(12'h088, d); check("R3 active copy word 2", d, 32'hDEAD_BEEF);
    check("R10 irq with enabled flag", {31'b0, irq_o}, 32'h1);

    // R7 line thresholds
    pulse_line(0, 2);
    rd(12'h01C, d); check("R7 below threshold", d, 32'h0100_0002);
    pulse_line(0, 1);
    rd(12'h01C, d); check("R7 output 0 at threshold", d, 32'h0100_0102);
    pulse_line(1, 5);
    rd(12'h01C, d); check("R7 output 1 at threshold", d, 32'h0100_0302);
    rd_latched(12'h014, d); check("R11 line counts", d, 32'h0005_0003);

    // R9 write-one-to-clear
    wr(12'h01C, 32'h0100_0002);
    rd(12'h01C, d); check("R9 partial clear", d, 32'h0000_0300);
    wr(12'h01C, 32'hFFFF_FFFF);
    rd(12'h01C, d); check("R9 clear all", d, 32'h0);
    @(negedge clk);
    check("R10 irq drops", {31'b0, irq_o}, 32'h0);

    // R8 statistics
    pulse_stats();
    rd(12'h01C, d); check("R8 stats flag", d, 32'h0001_0000);
    wr(12'h01C, 32'hFFFF_FFFF);

    // R9 set wins over same-cycle clear
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 12'h01C; bus_wdata = 32'hFFFF_FFFF; stats_i = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; stats_i = 1'b0;
    rd(12'h01C, d); check("R9 set over clear", d, 32'h0001_0000);
    wr(12'h01C, 32'hFFFF_FFFF);

    // R5 end of frame
    pulse_eof();
    rd_latched(12'h008, d); check("R5 idle after frame end", d, 32'h0);
    rd(12'h01C, d); check("R5 end flag", d, 32'h1);
    rd_latched(12'h00C, d); check("R5 frame count", d, 32'h1);
    wr(12'h01C, 32'hFFFF_FFFF);
    pulse_eof();
    rd(12'h01C, d); check("R5 idle end ignored flag", d, 32'h0);
    rd_latched(12'h00C, d); check("R5 idle end ignored count", d, 32'h1);

    // R4 frame start without job
    pulse_sof();
    rd_latched(12'h010, d); check("R4 frame without job error", d, 32'h2);
    rd_latched(12'h008, d); check("R4 state unchanged", d, 32'h0);
    rd(12'h01C, d); check("R4 no flags", d, 32'h0);

    // R6 overflow
    wr(12'h004, 32'h1);
    wr(12'h004, 32'h1);
    rd_latched(12'h010, d); check("R6 overflow error", d, 32'h3);
    rd_latched(12'h008, d); check("R6 still one job queued", d, 32'h3);

    // R11 latch holds old value
    pulse_sof();
    rd(12'h008, d); check("R11 stale until latch", d, 32'h3);
    rd_latched(12'h008, d); check("R11 fresh after latch", d, 32'h4);
    wr(12'h01C, 32'hFFFF_FFFF);

    // R12 abort
    wr(12'h004, 32'h2);
    rd_latched(12'h008, d); check("R12 idle after abort", d, 32'h0);
    rd_latched(12'h00C, d); check("R12 frame count kept", d, 32'h1);
    wr(12'h004, 32'h3);
    rd_latched(12'h008, d); check("R13 abort overrides queue", d, 32'h0);

    // R10 masking
    wr(12'h018, 32'h0);
    pulse_stats();
    @(negedge clk);
    check("R10 masked irq low", {31'b0, irq_o}, 32'h0);
    rd(12'h01C, d); check("R10 flag still recorded", d, 32'h0001_0000);
    wr(12'h018, 32'h0001_0000);
    @(negedge clk);
    check("R10 irq after enable", {31'b0, irq_o}, 32'h1);

    // R13 reset command
    wr(12'h004, 32'h4);
    rd(12'h01C, d); check("R13 flags cleared", d, 32'h0);
    rd(12'h018, d); check("R13 enable cleared", d, 32'h0);
    rd(12'h00C, d); check("R13 latched count cleared", d, 32'h0);
    rd_latched(12'h010, d); check("R13 errors cleared", d, 32'h0);
    rd(12'h080, d); check("R13 active copy cleared", d, 32'h0);
    rd(12'h040, d); check("R13 shadow kept", d, 32'h3);
    check("R13 irq low", {31'b0, irq_o}, 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule